// File: doc/BRIEF.md
# Round-Robin Slave Arbiter with Slot Limit

This block decides which of several bus masters may drive one shared slave port. Requests are served in rotating order. After a master has been served, the search for the next one begins at the master one index above it and wraps past the highest index. After reset no master has been served yet, so the search begins at index 0. When several masters request in the same cycle, the lowest index therefore wins first and the rest follow in turn.

The grant changes only at safe points. These are an idle bus cycle, the completion of the final beat of the granted master's burst, and the completion of any beat once the slot timer has run out. The slot timer is loaded from a programmable limit each time an access is granted. It then counts down once per clock, so the timer caps how long one master can hold a slow slave. A limit of zero turns the timer off.

When nobody requests, a parking policy chooses what the grant shows. It can show no master, the master served most recently, or a configured master.

Top module: `rr_slot_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant` is all zeros and `grant_idx` is 0.
- R2: With no service history, when several masters request at once, the lowest-numbered requester is granted.
- R3: At a re-arbitration point with requests present, the winner is the first requester found by searching upward from one above the last served master, wrapping from N-1 to 0.
- R4: A held grant changes only when at least one of these is true: `bus_idle` is high, `beat_done` is high together with the granted master's `burst_last` bit, or `beat_done` is high while the slot timer has expired. When `grant` is all zeros, re-arbitration happens every cycle. `burst_last` without `beat_done` has no effect.
- R5: Each grant to a requesting master loads the slot timer with `slot_limit` L, and the timer counts down once per cycle. If L is non-zero, then from the L-th cycle after the grant, counting the first grant cycle as 0, a `beat_done` re-arbitrates. An expired timer without `beat_done` does not.
- R6: A `slot_limit` of 0 disables the timer, so `beat_done` alone never moves the grant.
- R7: With `park_mode` = 2'b00, a re-arbitration that finds no requester leaves `grant` all zeros.
- R8: With `park_mode` = 2'b01, a re-arbitration that finds no requester grants the last served master. With no history it grants nobody.
- R9: With `park_mode` = 2'b10, a re-arbitration that finds no requester grants `park_fixed_idx`. The code 2'b11 behaves as 2'b00.
- R10: A grant change appears on the clock edge that ends the cycle in which the re-arbitration condition holds.
- R11: `grant` is zero-or-one-hot, and `grant_idx` equals the index of its set bit, or 0 when no bit is set.

Bit i of `req` and `burst_last` belongs to master i. Bit i of `grant` is set when master i is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MASTERS | Request line per master |
| burst_last | input | N_MASTERS | Per-master flag: the current beat is the final beat of its burst |
| beat_done | input | 1 | The granted master's current beat completes this cycle |
| bus_idle | input | 1 | No transfer is in progress on the slave this cycle |
| park_mode | input | 2 | Parking policy: 00 none, 01 last served, 10 fixed, 11 none |
| park_fixed_idx | input | IDX_W | Master to park on in fixed mode |
| slot_limit | input | SLOT_W | Slot timer reload value; 0 disables the timer |
| grant | output | N_MASTERS | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted master |

## Verification
The properties assume that `bus_idle` and `beat_done` come from the slave side of a single shared bus. They also assume that `park_mode`, `park_fixed_idx` and `slot_limit` change only between accesses, never during a held grant, and that `park_fixed_idx` is below N_MASTERS. The stimulus follows these rules. It changes the configuration only in idle cycles. It raises `beat_done` only while a grant is held, and it keeps `slot_limit` constant within each slot-timer sequence. Every input changes at the falling edge, so each rising edge samples settled values.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_FIXED = 2'b10,
    PARK_RSVD  = 2'b11
  } park_mode_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating first-one search: scans req beginning at start_idx, wrapping at N.
module arb_rr_pick #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]     start_idx,
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx
);

  always_comb begin
    int unsigned pos;
    found   = 1'b0;
    win_idx = '0;
    pos     = 0;
    for (int k = 0; k < N_MASTERS; k++) begin
      pos = int'(start_idx) + k;
      if (pos >= N_MASTERS) pos = pos - N_MASTERS;
      if (!found && req[pos]) begin
        found   = 1'b1;
        win_idx = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/arb_park_sel.sv
// Chooses the next grant owner: the search winner, or the parking target.
module arb_park_sel
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  park_mode_e       mode,
  input  logic             has_hist,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [IDX_W-1:0] fixed_idx,
  output logic             nxt_vld,
  output logic [IDX_W-1:0] nxt_idx
);

  logic fixed_ok;

  assign fixed_ok = (int'(fixed_idx) < N_MASTERS);

  always_comb begin
    nxt_vld = 1'b0;
    nxt_idx = '0;
    if (found) begin
      nxt_vld = 1'b1;
      nxt_idx = win_idx;
    end else begin
      unique case (mode)
        PARK_LAST: begin
          nxt_vld = has_hist;
          nxt_idx = has_hist ? last_idx : '0;
        end
        PARK_FIXED: begin
          nxt_vld = fixed_ok;
          nxt_idx = fixed_ok ? fixed_idx : '0;
        end
        default: begin
          nxt_vld = 1'b0;
          nxt_idx = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/arb_slot_timer.sv
// Down-counter reloaded at each grant; flags expiry when it reaches zero.
module arb_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] limit,
  output logic              expired
);

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              en_q, en_d;
  logic              cnt_upd;

  always_comb begin
    cnt_upd = load | (cnt_q != '0);
    cnt_d   = load ? limit : (cnt_q - SLOT_W'(1));
    en_d    = load ? (limit != '0) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (load)    en_q  <= en_d;
    end
  end

  assign expired = en_q & (cnt_q == '0);

endmodule

// File: rtl/rr_slot_arbiter.sv
module rr_slot_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int SLOT_W    = 8,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] burst_last,
  input  logic                 beat_done,
  input  logic                 bus_idle,
  input  logic [1:0]           park_mode,
  input  logic [IDX_W-1:0]     park_fixed_idx,
  input  logic [SLOT_W-1:0]    slot_limit,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]     grant_idx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_MASTERS - 1);

  logic             gnt_vld_q, gnt_vld_d;
  logic [IDX_W-1:0] gnt_idx_q, gnt_idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             hist_q, hist_d;

  logic             rearb, load;
  logic             slot_expired;
  logic             found;
  logic [IDX_W-1:0] win_idx, start_idx;
  logic             nxt_vld;
  logic [IDX_W-1:0] nxt_idx;
  park_mode_e       mode;

  assign mode = park_mode_e'(park_mode);

  // Search origin: one above the last served master, or 0 without history.
  always_comb begin
    if (!hist_q)               start_idx = '0;
    else if (last_q == TOP_IDX) start_idx = '0;
    else                        start_idx = last_q + IDX_W'(1);
  end

  arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) pick_i (
    .req       (req),
    .start_idx (start_idx),
    .found     (found),
    .win_idx   (win_idx)
  );

  arb_park_sel #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) park_i (
    .found     (found),
    .win_idx   (win_idx),
    .mode      (mode),
    .has_hist  (hist_q),
    .last_idx  (last_q),
    .fixed_idx (park_fixed_idx),
    .nxt_vld   (nxt_vld),
    .nxt_idx   (nxt_idx)
  );

  arb_slot_timer #(.SLOT_W(SLOT_W)) slot_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .limit   (slot_limit),
    .expired (slot_expired)
  );

  // Safe points for moving the grant.
  always_comb begin
    rearb = ~gnt_vld_q
          | bus_idle
          | (beat_done & (burst_last[gnt_idx_q] | slot_expired));
    load  = rearb & found;
  end

  // Next-state process.
  always_comb begin
    gnt_vld_d = gnt_vld_q;
    gnt_idx_d = gnt_idx_q;
    last_d    = last_q;
    hist_d    = hist_q;
    if (rearb) begin
      gnt_vld_d = nxt_vld;
      gnt_idx_d = nxt_vld ? nxt_idx : '0;
    end
    if (load) begin
      last_d = win_idx;
      hist_d = 1'b1;
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
      last_q    <= '0;
      hist_q    <= 1'b0;
    end else begin
      if (rearb) begin
        gnt_vld_q <= gnt_vld_d;
        gnt_idx_q <= gnt_idx_d;
      end
      if (load) begin
        last_q <= last_d;
        hist_q <= hist_d;
      end
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
    assign grant[g] = gnt_vld_q & (gnt_idx_q == IDX_W'(g));
  end

  assign grant_idx = gnt_idx_q;

endmodule

// File: rtl/rr_slot_arbiter_chk.sv
module rr_slot_arbiter_chk #(
  parameter int N_MASTERS = 4,
  parameter int SLOT_W    = 8,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] burst_last,
  input logic                 beat_done,
  input logic                 bus_idle,
  input logic [1:0]           park_mode,
  input logic [IDX_W-1:0]     park_fixed_idx,
  input logic [SLOT_W-1:0]    slot_limit,
  input logic [N_MASTERS-1:0] grant,
  input logic [IDX_W-1:0]     grant_idx
);

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grant_idx]);

  // R11
  grant_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (grant_idx == '0));

  // R4
  hold_mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !bus_idle && !beat_done) |=> $stable(grant));

  // R3
  winner_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && req != '0) |=> ((grant & $past(req)) != '0));

  // R7
  no_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_mode == 2'b00 && req == '0 && (bus_idle || grant == '0)) |=> (grant == '0));

  // R9
  fixed_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_mode == 2'b10 && req == '0 && bus_idle) |=>
      (grant != '0 && grant_idx == $past(park_fixed_idx)));

endmodule

bind rr_slot_arbiter rr_slot_arbiter_chk #(
  .N_MASTERS (N_MASTERS),
  .SLOT_W    (SLOT_W),
  .IDX_W     (IDX_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req            (req),
  .burst_last     (burst_last),
  .beat_done      (beat_done),
  .bus_idle       (bus_idle),
  .park_mode      (park_mode),
  .park_fixed_idx (park_fixed_idx),
  .slot_limit     (slot_limit),
  .grant          (grant),
  .grant_idx      (grant_idx)
);

// File: tb/rr_slot_arbiter_tb_top.sv
module rr_slot_arbiter_tb_top;

  localparam int N = 4;
  localparam int SW = 8;
  localparam int IW = 2;
  localparam int NVEC = 14;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [N-1:0]  burst_last;
  logic          beat_done;
  logic          bus_idle;
  logic [1:0]    park_mode;
  logic [IW-1:0] park_fixed_idx;
  logic [SW-1:0] slot_limit;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;

  int checks;
  int errors;

  rr_slot_arbiter #(.N_MASTERS(N), .SLOT_W(SW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .burst_last     (burst_last),
    .beat_done      (beat_done),
    .bus_idle       (bus_idle),
    .park_mode      (park_mode),
    .park_fixed_idx (park_fixed_idx),
    .slot_limit     (slot_limit),
    .grant          (grant),
    .grant_idx      (grant_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row layout: {req[3:0], burst_last[3:0], beat_done, bus_idle, park_mode[1:0], expected grant[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b1111, 4'b0000, 1'b0, 1'b1, 2'b00, 4'b0001},  // R2: no history, lowest wins
    {4'b1111, 4'b0000, 1'b0, 1'b0, 2'b00, 4'b0001},  // R4: busy, no beat end
    {4'b1111, 4'b0000, 1'b1, 1'b0, 2'b00, 4'b0001},  // R6: limit 0, beat alone holds
    {4'b1111, 4'b1111, 1'b1, 1'b0, 2'b00, 4'b0010},  // R4: burst end moves on
    {4'b1111, 4'b0000, 1'b0, 1'b1, 2'b00, 4'b0100},  // R3: rotation
    {4'b0001, 4'b0000, 1'b0, 1'b1, 2'b00, 4'b0001},  // R3: wrap past top
    {4'b0000, 4'b0000, 1'b0, 1'b1, 2'b00, 4'b0000},  // R7: no parking
    {4'b0000, 4'b0000, 1'b0, 1'b1, 2'b01, 4'b0001},  // R8: park on last served
    {4'b1000, 4'b0000, 1'b0, 1'b1, 2'b01, 4'b1000},  // R3: single requester
    {4'b0000, 4'b0000, 1'b0, 1'b1, 2'b01, 4'b1000},  // R8: park keeps last
    {4'b0000, 4'b0000, 1'b0, 1'b1, 2'b10, 4'b0100},  // R9: fixed park
    {4'b0000, 4'b0000, 1'b0, 1'b1, 2'b11, 4'b0000},  // R9: reserved code acts as none
    {4'b0110, 4'b0000, 1'b0, 1'b1, 2'b10, 4'b0010},  // R3: search from above last (3)
    {4'b0110, 4'b1111, 1'b0, 1'b0, 2'b10, 4'b0010}   // R4: burst_last without beat_done
  };

  string tags [NVEC] = '{"R2", "R4", "R6", "R4", "R3", "R3", "R7",
                         "R8", "R3", "R8", "R9", "R9", "R3", "R4"};

  function automatic logic [IW-1:0] idx_of(input logic [N-1:0] g);
    idx_of = '0;
    for (int i = 0; i < N; i++) if (g[i]) idx_of = IW'(i);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp_g);
    checks++;
    if (grant !== exp_g) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp_g);
    end
    checks++;
    if (grant_idx !== idx_of(exp_g)) begin
      errors++;
      $display("FAIL R11 (%s) grant_idx actual=%0d expected=%0d", tag, grant_idx, idx_of(exp_g));
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] bl,
                       input logic bd, input logic idl, input logic [1:0] pm);
    req        = r;
    burst_last = bl;
    beat_done  = bd;
    bus_idle   = idl;
    park_mode  = pm;
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    drive('0, '0, 1'b0, 1'b1, 2'b00);
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    checks         = 0;
    errors         = 0;
    rst_n          = 1'b0;
    park_fixed_idx = IW'(2);
    slot_limit     = '0;
    drive('0, '0, 1'b0, 1'b1, 2'b00);

    // R1: reset state, and the first cycle after release with nobody requesting
    do_reset();
    @(negedge clk);
    step();
    check("R1 after release", '0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drive(VEC[v][15:12], VEC[v][11:8], VEC[v][7], VEC[v][6], VEC[v][5:4]);
      step();
      check(tags[v], VEC[v][3:0]);
    end

    // R2: sparse simultaneous requests after reset
    do_reset();
    @(negedge clk);
    drive(4'b1010, '0, 1'b0, 1'b1, 2'b00);
    step();
    check("R2 sparse", 4'b0010);

    // R8: last-served parking with no history grants nobody
    do_reset();
    @(negedge clk);
    drive('0, '0, 1'b0, 1'b1, 2'b01);
    step();
    check("R8 no history", '0);

    // R5 / R10: slot limit 3 breaks the access at cycle 3 on a beat boundary
    do_reset();
    @(negedge clk);
    slot_limit = 8'd3;
    drive(4'b0011, '0, 1'b0, 1'b1, 2'b00);
    step();                               // grant cycle 0 starts
    check("R5 grant", 4'b0001);
    for (int c = 0; c < 3; c++) begin     // cycles 0..2: timer not expired
      @(negedge clk);
      drive(4'b0011, '0, 1'b1, 1'b0, 2'b00);
      step();
      check("R5 hold before expiry", 4'b0001);
    end
    @(negedge clk);                       // cycle 3 expired, but no beat completes
    drive(4'b0011, '0, 1'b0, 1'b0, 2'b00);
    step();
    check("R5 expired without beat", 4'b0001);
    @(negedge clk);                       // beat completes: move on the next edge
    drive(4'b0011, '0, 1'b1, 1'b0, 2'b00);
    step();
    check("R10 break at beat edge", 4'b0010);

    // R6: with limit 0 the access continues through many beats
    do_reset();
    @(negedge clk);
    slot_limit = '0;
    drive(4'b0011, '0, 1'b0, 1'b1, 2'b00);
    step();
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      drive(4'b0011, '0, 1'b1, 1'b0, 2'b00);
      step();
    end
    check("R6 never expires", 4'b0001);

    summary();
  end

endmodule